// File: doc/BRIEF.md
# Prescaled Watchdog Timer with Status Flags

This block is a watchdog for a small processor core. An 8-bit watchdog counter advances once for every terminal count of a power-of-two prescaler. When that counter wraps past its all-ones value, the block emits a single-cycle timeout pulse that the system uses as a reset request. Firmware must stop this from happening by executing a clear-watchdog instruction often enough. The core's instruction decoder turns that instruction into the `kick` strobe.

The block also holds two status flags, both active low. `to_n` falls when a timeout occurs. `pd_n` falls when the core enters sleep. A clear strobe zeroes both counters and raises both flags in the same cycle. A sleep strobe also zeroes both counters, and lowers only the power-down flag. When the enable input is low, both counters are held at zero and no timeout can occur. Even then, the status flags still respond to the clear and sleep strobes.

Top module: `wdog_presc`

## Requirements
- R1: After reset, `timeout` is 0, `to_n` is 1 and `pd_n` is 1, and both counters start from zero.
- R2: A `kick` zeroes both the prescaler and the watchdog counter. No timeout is produced in the cycle that follows a `kick`. The next timeout comes exactly 256·2^`div_sel` cycles after the clocking edge that sampled the `kick`.
- R3: At the edge that samples `kick`, `to_n` and `pd_n` are both set to 1.
- R4: At the edge that samples `sleep` with `kick` low, `pd_n` is set to 0 and both counters are zeroed, while `to_n` keeps its value. If `kick` and `sleep` are high together, `kick` wins for the status flags.
- R5: When the watchdog counter wraps from FFh to 00h, `timeout` is 1 for exactly one cycle. At that same edge `to_n` goes to 0, and it stays 0 until a `kick` or a reset.
- R6: While `en` is 0, both counters are held at zero and `timeout` stays 0. Status updates from `kick` and `sleep` still take effect.
- R7: `div_sel` (a 3-bit field) sets the prescaler ratio to 2^`div_sel`, from 1:1 (value 0) up to 1:128 (value 7). The watchdog counter advances once per 2^`div_sel` enabled cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Watchdog enable; low holds both counters at zero |
| div_sel | input | 3 | Prescaler ratio select, ratio 2^div_sel |
| kick | input | 1 | Clear-watchdog strobe from the instruction decoder |
| sleep | input | 1 | Sleep-entry strobe |
| timeout | output | 1 | One-cycle pulse on watchdog overflow |
| to_n | output | 1 | Time-out status, 0 after an overflow |
| pd_n | output | 1 | Power-down status, 0 after sleep entry |

## Verification
On every cycle, the assertions check these properties: the timeout is a single-cycle pulse, `to_n` is low whenever a pulse is out, a disabled or just-cleared watchdog produces no pulse, and both strobes have their effect on the status flags. Two things cannot be expressed as short properties because they depend on 256·2^`div_sel` cycles of history: the exact overflow period for each prescaler ratio, and the way a sleep or clear restarts that period. The bench shows both, through directed runs at several ratios and a long random run compared cycle by cycle against a reference model.

// File: rtl/wdog_presc.sv
module wdog_presc #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             kick,
  input  logic             sleep,
  output logic             timeout,
  output logic             to_n,
  output logic             pd_n
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] pre_q, pre_mask;
  logic [CNT_W-1:0] cnt_q;
  logic             tick, restart, wrap;

  assign pre_mask = ~({PRE_W{1'b1}} << div_sel);
  assign tick     = (pre_q & pre_mask) == pre_mask;
  assign restart  = !en || kick || sleep;
  assign wrap     = tick && (&cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= '0;
      cnt_q   <= '0;
      timeout <= 1'b0;
    end else if (restart) begin
      pre_q   <= '0;
      cnt_q   <= '0;
      timeout <= 1'b0;
    end else begin
      pre_q   <= tick ? '0 : pre_q + 1'b1;
      cnt_q   <= tick ? cnt_q + 1'b1 : cnt_q;
      timeout <= wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_n <= 1'b1;
      pd_n <= 1'b1;
    end else if (kick) begin
      to_n <= 1'b1;
      pd_n <= 1'b1;
    end else begin
      if (sleep) pd_n <= 1'b0;
      if (!restart && wrap) to_n <= 1'b0;
    end
  end

  p_pulse_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !timeout);
  p_pulse_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !to_n);
  p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !timeout);
  p_kick_no_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !timeout);
  p_kick_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (to_n && pd_n));
  p_sleep_pd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !kick) |=> (!pd_n && $stable(to_n)));
endmodule

// File: tb/wdog_presc_test.sv
module wdog_presc_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [2:0] div_sel = 3'd0;
  logic kick = 1'b0;
  logic sleep = 1'b0;
  logic timeout, to_n, pd_n;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int m_pre, m_cnt;
  bit m_to, m_ton, m_pdn;

  always #2.5 clk = ~clk;

  wdog_presc uut (
    .clk(clk), .rst_n(rst_n), .en(en), .div_sel(div_sel),
    .kick(kick), .sleep(sleep), .timeout(timeout), .to_n(to_n), .pd_n(pd_n)
  );

  function automatic int ratio(input logic [2:0] s);
    return 1 << s;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_edge();
    m_to = 0;
    if (kick) begin m_ton = 1; m_pdn = 1; end
    else if (sleep) m_pdn = 0;
    if (!en || kick || sleep) begin
      m_pre = 0; m_cnt = 0;
    end else if (m_pre == ratio(div_sel) - 1) begin
      m_pre = 0;
      if (m_cnt == 255) begin m_cnt = 0; m_to = 1; m_ton = 0; end
      else m_cnt++;
    end else m_pre++;
  endtask

  task automatic step(input bit e, input logic [2:0] s, input bit k, input bit sl, input bit cmp);
    en = e; div_sel = s; kick = k; sleep = sl;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (cmp) begin
      check("R5", "timeout", timeout, m_to);
      check("R5", "to_n", to_n, m_ton);
      check("R4", "pd_n", pd_n, m_pdn);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic run_until_pulse(input logic [2:0] s, output int cycles);
    cycles = 0;
    do begin
      step(1, s, 0, 0, 0);
      cycles++;
    end while (!timeout && cycles < 40000);
  endtask

  initial begin
    #(150000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    int cyc;
    m_pre = 0; m_cnt = 0; m_to = 0; m_ton = 1; m_pdn = 1;
    #12 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "timeout after reset", timeout, 0);
    check("R1", "to_n after reset", to_n, 1);
    check("R1", "pd_n after reset", pd_n, 1);

    // R7 ratio 1:1, first period from reset counts from zero (R1)
    step(1, 3'd0, 1, 0, 0);
    run_until_pulse(3'd0, cyc);
    check("R7", "period at ratio 1", cyc, 256);
    check("R5", "to_n on pulse", to_n, 0);
    step(1, 3'd0, 0, 0, 0);
    check("R5", "pulse width", timeout, 0);
    check("R5", "to_n sticky", to_n, 0);

    // R3 kick restores flags
    step(1, 3'd0, 0, 1, 0);
    check("R4", "pd_n after sleep", pd_n, 0);
    check("R4", "to_n kept through sleep", to_n, 0);
    step(1, 3'd0, 1, 0, 0);
    check("R3", "to_n after kick", to_n, 1);
    check("R3", "pd_n after kick", pd_n, 1);

    // R7 ratio 1:8 and R2 restart
    step(1, 3'd3, 1, 0, 0);
    run_until_pulse(3'd3, cyc);
    check("R7", "period at ratio 8", cyc, 2048);
    step(1, 3'd2, 1, 0, 0);
    run_until_pulse(3'd2, cyc);
    check("R2", "period after kick at ratio 4", cyc, 1024);

    // R2 kick midway restarts the full period
    step(1, 3'd1, 1, 0, 0);
    for (int i = 0; i < 300; i++) step(1, 3'd1, 0, 0, 0);
    step(1, 3'd1, 1, 0, 0);
    run_until_pulse(3'd1, cyc);
    check("R2", "period after mid kick", cyc, 512);

    // R2 kick on the overflow cycle suppresses the pulse
    step(1, 3'd0, 1, 0, 0);
    for (int i = 0; i < 255; i++) step(1, 3'd0, 0, 0, 0);
    step(1, 3'd0, 1, 0, 0);
    check("R2", "kick at overflow blocks pulse", timeout, 0);
    check("R2", "to_n after kick at overflow", to_n, 1);

    // R4 sleep restarts period; kick wins over sleep
    for (int i = 0; i < 100; i++) step(1, 3'd0, 0, 0, 0);
    step(1, 3'd0, 0, 1, 0);
    run_until_pulse(3'd0, cyc);
    check("R4", "period after sleep", cyc, 256);
    step(1, 3'd0, 1, 1, 0);
    check("R4", "kick beats sleep pd_n", pd_n, 1);
    check("R4", "kick beats sleep to_n", to_n, 1);

    // R6 disabled: no pulse, status still updates
    cyc = 0;
    for (int i = 0; i < 700; i++) begin
      step(0, 3'd0, 0, 0, 0);
      if (timeout) cyc++;
    end
    check("R6", "pulses while disabled", cyc, 0);
    step(0, 3'd0, 0, 1, 0);
    check("R6", "pd_n responds while disabled", pd_n, 0);
    step(0, 3'd0, 1, 0, 0);
    check("R6", "pd_n kick while disabled", pd_n, 1);
    run_until_pulse(3'd0, cyc);
    check("R6", "period after enable", cyc, 256);

    // R7 largest ratio
    step(1, 3'd7, 1, 0, 0);
    run_until_pulse(3'd7, cyc);
    check("R7", "period at ratio 128", cyc, 32768);

    // random run against model, R2 R4 R5 R6 R7
    void'($urandom(32'h5eed));
    step(1, 3'd0, 1, 0, 0);
    m_pre = 0; m_cnt = 0; m_to = 0; m_ton = 1; m_pdn = 1;
    begin
      logic [2:0] s;
      s = 3'd0;
      for (int i = 0; i < 30000; i++) begin
        bit e, k, sl;
        int r;
        r = $urandom_range(0, 999);
        e = (r >= 5);
        k = ($urandom_range(0, 1999) == 0);
        sl = ($urandom_range(0, 2999) == 0);
        if (k) s = 3'($urandom_range(0, 2));
        step(e, s, k, sl, 1);
      end
    end
    finish_run();
  end
endmodule